// File: doc/BRIEF.md
# Serial Port Interrupt Status Controller

This block gathers the interrupt sources of a synchronous serial port and presents them to software through a small 32-bit register bus. Seven sources are tracked. Five of them latch a single-cycle event strobe until software clears them: end of transmission, transmit DMA complete, receive DMA complete, receive timeout and receive overrun. The other two follow FIFO fill levels and clear themselves. One combined interrupt line goes to the interrupt controller.

Software reads a raw status word that shows every source unmasked. It reads and writes an enable mask, and reads a masked status word that holds raw AND mask. It clears latched sources by writing ones to a write-only clear register. A transmit mode input changes the meaning of the transmit source. With the input low, the source reports a FIFO that is half empty or emptier. With the input high, it reports that the final bit has left the shifter, and it holds that report until new data enters the FIFO.

Top module: `ssp_irq_ctrl`

## Requirements
- R1: The status, mask and clear words all use the same bit positions: bit 0 receive overrun, bit 1 receive timeout, bit 2 receive FIFO, bit 3 transmit, bit 4 receive DMA done, bit 5 transmit DMA done, bit 6 end of transmission. Bits 31 to 7 of every read return 0.
- R2: The register word offsets are: byte address 0x0 mask (read/write), 0x4 raw status (read-only), 0x8 masked status (raw AND mask), 0xC clear (write-only, reads 0). Read data appears on `bus_rdata` in the cycle after the read request.
- R3: A strobe on a latched source sets its raw bit at the next clock edge. The bit stays set until a bus write to the clear register carries 1 in that position. Writing 0 there has no effect.
- R4: If a latched source's strobe arrives in the same cycle as a clear write to its bit, the bit ends up set.
- R5: With `eot_mode` = 0, raw bit 3 is 1 in the cycle after `tx_fill` is at most TX_DEPTH/2, and 0 in the cycle after `tx_fill` is above it.
- R6: With `eot_mode` = 1, raw bit 3 is set by `ev_last_bit` and is cleared in the cycle after `tx_fill` is nonzero. It does not set again without a new `ev_last_bit`.
- R7: Raw bit 2 is 1 in the cycle after `rx_fill` is at least RX_DEPTH/2, and 0 otherwise.
- R8: Clear writes to bits 2 and 3 have no effect. Bus writes to the raw, masked or clear addresses leave the mask unchanged.
- R9: `irq` is a register. It is 1 in the cycle after any masked status bit is 1, and 0 in the cycle after none is.
- R10: Synchronous reset sets the mask, all raw bits, `bus_rdata` and `irq` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W (4) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eot_mode | input | 1 | Transmit source selects end-of-transmission meaning |
| tx_fill | input | TXC_W (4) | Transmit FIFO entry count |
| rx_fill | input | RXC_W (4) | Receive FIFO entry count |
| ev_last_bit | input | 1 | Strobe: final data bit shifted out |
| ev_tx_dma | input | 1 | Strobe: transmit DMA finished |
| ev_rx_dma | input | 1 | Strobe: receive DMA finished |
| ev_rx_timeout | input | 1 | Strobe: receive timeout |
| ev_rx_overrun | input | 1 | Strobe: receive overrun |
| irq | output | 1 | Combined registered interrupt |

## Verification
The assertions assume that the fill counts never exceed the FIFO depths. They also assume that every event strobe and bus request is a synchronous signal that is stable across the sampling edge. The bench changes every input on the falling clock edge only and keeps the fill counts inside 0 to 8. The sticky assertions also assume that a clear takes effect only through a full bus write request. For that reason the bench drives `bus_sel` and `bus_wr` together for exactly one cycle per access.

// File: rtl/ssp_irq_pkg.sv
package ssp_irq_pkg;
  localparam int NSRC      = 7;
  localparam int B_OVR     = 0;
  localparam int B_TMO     = 1;
  localparam int B_RXF     = 2;
  localparam int B_TXF     = 3;
  localparam int B_RXDMA   = 4;
  localparam int B_TXDMA   = 5;
  localparam int B_EOT     = 6;
  // sources that latch until cleared by software
  localparam logic [NSRC-1:0] LATCHED = 7'b111_0011;
  // word indices of the register slots
  localparam logic [1:0] W_MASK   = 2'd0;
  localparam logic [1:0] W_RAW    = 2'd1;
  localparam logic [1:0] W_MASKED = 2'd2;
  localparam logic [1:0] W_CLEAR  = 2'd3;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/ssp_irq_latch.sv
module ssp_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (q_o && !clr_i) |=> q_o);
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
    (!q_o && !set_i) |=> !q_o);
endmodule

// File: rtl/ssp_irq_tx_src.sv
module ssp_irq_tx_src #(
  parameter int TX_DEPTH = 8,
  parameter int TXC_W    = $clog2(TX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eot_mode,
  input  logic [TXC_W-1:0] tx_fill,
  input  logic             ev_last_bit,
  output logic             tx_raw_o
);
  localparam logic [TXC_W-1:0] TX_HALF = TXC_W'(TX_DEPTH / 2);

  logic done_pend;
  logic fifo_low;

  assign fifo_low = (tx_fill <= TX_HALF);

  // drained-shifter flag, held until fresh data arrives
  always_ff @(posedge clk) begin
    if (rst)                 done_pend <= 1'b0;
    else if (tx_fill != '0)  done_pend <= 1'b0;
    else if (ev_last_bit)    done_pend <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) tx_raw_o <= 1'b0;
    else     tx_raw_o <= eot_mode ? ((tx_fill == '0) && (done_pend || ev_last_bit))
                                  : fifo_low;
  end

  assert_level_low_R5: assert property (@(posedge clk) disable iff (rst)
    (!eot_mode && tx_fill <= TX_HALF) |=> tx_raw_o);
  assert_level_high_R5: assert property (@(posedge clk) disable iff (rst)
    (!eot_mode && tx_fill > TX_HALF) |=> !tx_raw_o);
  assert_data_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (eot_mode && tx_fill != '0) |=> !tx_raw_o);
  assert_rearm_R6: assert property (@(posedge clk) disable iff (rst)
    (eot_mode && !tx_raw_o && !ev_last_bit && $past(eot_mode)) |=> !tx_raw_o);
endmodule

// File: rtl/ssp_irq_regs.sv
module ssp_irq_regs
  import ssp_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  src_vec_t          raw_i,
  output src_vec_t          mask_o,
  output src_vec_t          clr_o
);
  logic [1:0] widx;
  logic       wr_en, rd_en;
  src_vec_t   rd_sel;
  logic       unused_bits;

  assign widx  = bus_addr[3:2];
  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:NSRC]};

  // clear pulses only reach the latched sources
  assign clr_o = (wr_en && widx == W_CLEAR) ? (bus_wdata[NSRC-1:0] & LATCHED) : '0;

  always_ff @(posedge clk) begin
    if (rst)                            mask_o <= '0;
    else if (wr_en && widx == W_MASK)   mask_o <= bus_wdata[NSRC-1:0];
  end

  always_comb begin
    unique case (widx)
      W_MASK:   rd_sel = mask_o;
      W_RAW:    rd_sel = raw_i;
      W_MASKED: rd_sel = raw_i & mask_o;
      default:  rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= {{(32-NSRC){1'b0}}, rd_sel};
  end

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[31:NSRC] == '0);
  assert_masked_read_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && widx == W_MASKED) |=> bus_rdata[NSRC-1:0] == ($past(raw_i) & $past(mask_o)));
  assert_mask_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && widx == W_MASK)) |=> $stable(mask_o));
endmodule

// File: rtl/ssp_irq_ctrl.sv
module ssp_irq_ctrl
  import ssp_irq_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int ADDR_W   = 4,
  parameter int TXC_W    = $clog2(TX_DEPTH + 1),
  parameter int RXC_W    = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              eot_mode,
  input  logic [TXC_W-1:0]  tx_fill,
  input  logic [RXC_W-1:0]  rx_fill,
  input  logic              ev_last_bit,
  input  logic              ev_tx_dma,
  input  logic              ev_rx_dma,
  input  logic              ev_rx_timeout,
  input  logic              ev_rx_overrun,
  output logic              irq
);
  localparam logic [RXC_W-1:0] RX_HALF = RXC_W'(RX_DEPTH / 2);

  src_vec_t raw, mask, clr, ev;
  logic     rx_raw, tx_raw;

  assign ev = '{B_EOT: ev_last_bit, B_TXDMA: ev_tx_dma, B_RXDMA: ev_rx_dma,
                B_TMO: ev_rx_timeout, B_OVR: ev_rx_overrun, default: 1'b0};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (LATCHED[i]) begin : g_latch
      ssp_irq_latch u_latch (
        .clk(clk), .rst(rst), .set_i(ev[i]), .clr_i(clr[i]), .q_o(raw[i]));
    end else if (i == B_TXF) begin : g_tx
      assign raw[i] = tx_raw;
    end else begin : g_rx
      assign raw[i] = rx_raw;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rx_raw <= 1'b0;
    else     rx_raw <= (rx_fill >= RX_HALF);
  end

  ssp_irq_tx_src #(.TX_DEPTH(TX_DEPTH), .TXC_W(TXC_W)) u_tx (
    .clk(clk), .rst(rst), .eot_mode(eot_mode), .tx_fill(tx_fill),
    .ev_last_bit(ev_last_bit), .tx_raw_o(tx_raw));

  ssp_irq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .raw_i(raw), .mask_o(mask), .clr_o(clr));

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(raw & mask);
  end

  assert_rx_level_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_fill >= RX_HALF) |=> raw[B_RXF]);
  assert_irq_up_R9: assert property (@(posedge clk) disable iff (rst)
    (|(raw & mask)) |=> irq);
  assert_irq_down_R9: assert property (@(posedge clk) disable iff (rst)
    !(|(raw & mask)) |=> !irq);
  assert_fifo_clear_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (raw[B_RXF] && rx_fill >= RX_HALF) |=> raw[B_RXF]);
endmodule

// File: tb/tb_ssp_irq_ctrl.sv
module tb_ssp_irq_ctrl;
  logic clk = 0, rst = 1;
  logic bus_sel = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic eot_mode = 0;
  logic [3:0] tx_fill = 0, rx_fill = 0;
  logic ev_last_bit = 0, ev_tx_dma = 0, ev_rx_dma = 0, ev_rx_timeout = 0, ev_rx_overrun = 0;
  logic irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic mon_due = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ssp_irq_ctrl dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: one expected item per read request
  always @(posedge clk) mon_due <= bus_sel && !bus_wr;
  always @(negedge clk) begin
    if (mon_due) begin
      if (exp_q.size() == 0) check("SB underflow", 32'h1, 32'h0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic pulse_all(input logic [4:0] v);
    @(negedge clk);
    {ev_last_bit, ev_tx_dma, ev_rx_dma, ev_rx_timeout, ev_rx_overrun} = v;
    @(negedge clk);
    {ev_last_bit, ev_tx_dma, ev_rx_dma, ev_rx_timeout, ev_rx_overrun} = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      check("watchdog", 32'h1, 32'h0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 irq after reset", {31'b0, irq}, 0);
    check("R10 rdata after reset", bus_rdata, 0);
    rst = 0;
    rd(4'h0, 32'h0, "R10 mask reset");
    rd(4'h4, 32'h08, "R5 tx low at fill 0");
    rd(4'h8, 32'h0, "R2 masked zero with mask 0");
    check("R9 irq masked off", {31'b0, irq}, 0);
    tx_fill = 6;
    rd(4'h4, 32'h0, "R5 tx high at fill 6");
    tx_fill = 4;
    rd(4'h4, 32'h08, "R5 tx boundary fill 4");
    tx_fill = 6; rx_fill = 4;
    rd(4'h4, 32'h04, "R7 rx at half");
    rx_fill = 3;
    rd(4'h4, 32'h0, "R7 rx below half");
    pulse_all(5'b01000);
    rd(4'h4, 32'h20, "R3 tx dma set");
    wr(4'hC, 32'h0);
    rd(4'h4, 32'h20, "R3 zero write keeps");
    wr(4'h0, 32'h7F);
    check("R9 irq one cycle late", {31'b0, irq}, 0);
    @(negedge clk);
    check("R9 irq raised", {31'b0, irq}, 1);
    rd(4'h0, 32'h7F, "R2 mask readback");
    rd(4'h8, 32'h20, "R2 masked word");
    wr(4'hC, 32'h20);
    rd(4'h4, 32'h0, "R3 cleared");
    check("R9 irq dropped", {31'b0, irq}, 0);
    // R4: event and clear in the same cycle
    @(negedge clk);
    ev_rx_overrun = 1; bus_sel = 1; bus_wr = 1; bus_addr = 4'hC; bus_wdata = 32'h1;
    @(negedge clk);
    ev_rx_overrun = 0; bus_sel = 0; bus_wr = 0;
    rd(4'h4, 32'h01, "R4 event beats clear");
    wr(4'hC, 32'h03);
    rd(4'h4, 32'h0, "R3 overrun cleared");
    // R8: clearing level bits and writing other slots
    tx_fill = 2; rx_fill = 5;
    wr(4'hC, 32'h0C);
    rd(4'h4, 32'h0C, "R8 level bits ignore clear");
    wr(4'h4, 32'h0); wr(4'h8, 32'h0); wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h0, 32'h7F, "R8 mask untouched");
    rd(4'hC, 32'h0, "R2 clear reads zero");
    rx_fill = 0;
    // R6: end-of-transmission mode
    eot_mode = 1; tx_fill = 0;
    rd(4'h4, 32'h0, "R6 no source before last bit");
    pulse_all(5'b10000);
    rd(4'h4, 32'h48, "R6 last bit sets tx and eot");
    wr(4'hC, 32'h40);
    rd(4'h4, 32'h08, "R6 tx holds while empty");
    tx_fill = 1;
    rd(4'h4, 32'h0, "R6 data clears tx");
    tx_fill = 0;
    rd(4'h4, 32'h0, "R6 no rearm without event");
    // R1: all sources at once
    eot_mode = 0; rx_fill = 8;
    pulse_all(5'b11111);
    rd(4'h8, 32'h7F, "R1 full bit layout");
    wr(4'h0, 32'h01);
    rd(4'h8, 32'h01, "R1 overrun at bit 0");
    wr(4'h0, 32'h40);
    rd(4'h8, 32'h40, "R1 eot at bit 6");
    wr(4'h0, 32'h0);
    @(negedge clk);
    check("R9 irq zero with mask 0", {31'b0, irq}, 0);
    repeat (2) @(negedge clk);
    check("SB drained", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule